// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, A and B. Each bus is presented as three separate signals, so the pad tri-states stay outside the block: an incoming value, a flag that says another device is driving that bus, and an outgoing value with its own output enable. Traffic in each direction can pass through live from the opposite bus, or it can come from a storage register owned by that direction. Each register is loaded on the rising edge of its own capture strobe. The strobe is sampled by the core clock, and a load happens on every rising edge no matter how the selects and enables are set.

The controls are purely combinational and go through a small decoder. For each bus the decoder names one of four drive sources: `SRC_OFF` (the bus is input only), `SRC_LIVE` (the opposite bus is passed through), `SRC_STORED` (the direction's register is driven) and `SRC_KEEP`. The decoder picks `SRC_KEEP` for both buses when both directions are enabled and both are live. In that case the two outputs reinforce each other, and once every outside driver lets go, each bus keeps its last value. That value comes from a per-bus hold register, which is loaded from the resolved bus value on every core clock, so the mode has no combinational loop. The decoder has no stored state and moves straight between these four sources whenever a control input changes.

The resolved value of a bus is its incoming value when an outside driver is present. Otherwise it is the value the block itself drives onto it, or the held value when nothing drives the bus.

Top module: `dual_bus_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers and both hold registers to zero.
- R2: On a core-clock edge where `cap_ab` is 1 and was 0 at the previous edge, the A-to-B register loads the resolved A bus value. This happens whatever the enables and selects are.
- R3: On a core-clock edge where `cap_ba` is 1 and was 0 at the previous edge, the B-to-A register loads the resolved B bus value. This happens whatever the enables and selects are.
- R4: `en_ab` is active high and sets `b_oe`. `en_ba_n` is active low and sets `a_oe`. An output whose enable is inactive carries all zeros. With `en_ab`=0 and `en_ba_n`=1, both buses are inputs only.
- R5: When B is driven and keeper mode is off, `sel_ab`=0 drives the live resolved A value onto B, and `sel_ab`=1 drives the A-to-B register onto B.
- R6: When A is driven and keeper mode is off, `sel_ba`=0 drives the live resolved B value onto A, and `sel_ba`=1 drives the B-to-A register onto A.
- R7: Suppose A is driven live from B, there is no outside driver on A, and B carries an outside value. Raising both strobes then stores that B value in both registers.
- R8: Keeper mode is `en_ab`=1, `en_ba_n`=0, `sel_ab`=0 and `sel_ba`=0. In this mode, a value driven from outside onto one bus appears on both outputs. With no outside driver on either bus, each output keeps the last value of its own bus.
- R9: With both selects 1 and both directions enabled, `b_out` shows the A-to-B register and `a_out` shows the B-to-A register at the same time, whatever the outside drivers are doing.
- R10: A strobe that stays at 1 over several clock edges loads its register only once. Register contents change only on a 0-to-1 strobe transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples strobes and loads registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ab | input | 1 | Drive enable toward B, active high |
| en_ba_n | input | 1 | Drive enable toward A, active low |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored |
| cap_ab | input | 1 | Capture strobe of the A-to-B register |
| cap_ba | input | 1 | Capture strobe of the B-to-A register |
| a_in | input | W | Value seen on bus A |
| a_ext | input | 1 | 1 when an outside device drives bus A |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Output enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_ext | input | 1 | 1 when an outside device drives bus B |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Output enable for bus B |

## Verification
The bench builds the block with the default width of 8. At that width every data pattern is easy to read, and the whole control space fits in a six-bit word: two enables, two selects and two outside-driver flags. Directed steps cover the reset state, both capture paths, re-capture of held strobes, the store-into-both case, stored swap and the keeper sequence. A long pseudo-random walk then visits all 64 control combinations many times, with strobe edges mixed in. A reference model in the bench, built from the mode table, follows both registers and both held values.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2,
        SRC_KEEP   = 2'd3
    } drv_src_e;

endpackage

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
    import xcvr_pkg::*;
(
    input  logic     en_ab,
    input  logic     en_ba_n,
    input  logic     sel_ab,
    input  logic     sel_ba,
    output drv_src_e src_a,
    output drv_src_e src_b
);

    logic drive_a;
    logic keeper;

    assign drive_a = !en_ba_n;
    assign keeper  = en_ab && drive_a && !sel_ab && !sel_ba;

    always_comb begin
        unique case ({keeper, drive_a, sel_ba})
            3'b100, 3'b101, 3'b110: src_a = SRC_KEEP;
            3'b111:                 src_a = SRC_KEEP;
            3'b010:                 src_a = SRC_LIVE;
            3'b011:                 src_a = SRC_STORED;
            default:                src_a = SRC_OFF;
        endcase
    end

    always_comb begin
        unique case ({keeper, en_ab, sel_ab})
            3'b100, 3'b101, 3'b110: src_b = SRC_KEEP;
            3'b111:                 src_b = SRC_KEEP;
            3'b010:                 src_b = SRC_LIVE;
            3'b011:                 src_b = SRC_STORED;
            default:                src_b = SRC_OFF;
        endcase
    end

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rise
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    assign rise = strobe && !strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rise) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_res,
    input  logic [W-1:0] b_res,
    output logic [W-1:0] hold_a,
    output logic [W-1:0] hold_b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_a <= '0;
            hold_b <= '0;
        end else begin
            hold_a <= a_res;
            hold_b <= b_res;
        end
    end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic [W-1:0] a_in,
    input  logic         a_ext,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    input  logic         b_ext,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    drv_src_e       src_a, src_b;
    logic [W-1:0]   reg_ab, reg_ba;
    logic [W-1:0]   hold_a, hold_b;
    logic [W-1:0]   a_base, b_base;
    logic [W-1:0]   a_res, b_res;
    logic           rise_ab, rise_ba;

    xcvr_mode_dec u_dec (
        .en_ab   (en_ab),
        .en_ba_n (en_ba_n),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .src_a   (src_a),
        .src_b   (src_b)
    );

    xcvr_cap_reg #(.W(W)) u_reg_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ab),
        .d      (a_res),
        .q      (reg_ab),
        .rise   (rise_ab)
    );

    xcvr_cap_reg #(.W(W)) u_reg_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ba),
        .d      (b_res),
        .q      (reg_ba),
        .rise   (rise_ba)
    );

    xcvr_keeper #(.W(W)) u_keep (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_res  (a_res),
        .b_res  (b_res),
        .hold_a (hold_a),
        .hold_b (hold_b)
    );

    // Bus value ignoring any live pass-through from the opposite side.
    always_comb begin
        if (a_ext)                    a_base = a_in;
        else if (src_a == SRC_STORED) a_base = reg_ba;
        else                          a_base = hold_a;
        if (b_ext)                    b_base = b_in;
        else if (src_b == SRC_STORED) b_base = reg_ab;
        else                          b_base = hold_b;
    end

    // Resolved bus values; live paths only reference the other side's base.
    always_comb begin
        unique case (src_a)
            SRC_KEEP: a_res = a_ext ? a_in : (b_ext ? b_in : hold_a);
            SRC_LIVE: a_res = a_ext ? a_in : b_base;
            default:  a_res = a_base;
        endcase
        unique case (src_b)
            SRC_KEEP: b_res = b_ext ? b_in : (a_ext ? a_in : hold_b);
            SRC_LIVE: b_res = b_ext ? b_in : a_base;
            default:  b_res = b_base;
        endcase
    end

    always_comb begin
        unique case (src_a)
            SRC_OFF:    a_out = '0;
            SRC_LIVE:   a_out = b_base;
            SRC_STORED: a_out = reg_ba;
            SRC_KEEP:   a_out = b_ext ? b_in : (a_ext ? a_in : hold_a);
            default:    a_out = '0;
        endcase
        unique case (src_b)
            SRC_OFF:    b_out = '0;
            SRC_LIVE:   b_out = a_base;
            SRC_STORED: b_out = reg_ab;
            SRC_KEEP:   b_out = a_ext ? a_in : (b_ext ? b_in : hold_b);
            default:    b_out = '0;
        endcase
    end

    assign a_oe = (src_a != SRC_OFF);
    assign b_oe = (src_b != SRC_OFF);

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_ab,
    input logic         en_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         cap_ab,
    input logic         cap_ba,
    input logic         a_ext,
    input logic         b_ext,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] reg_ab,
    input logic [W-1:0] reg_ba,
    input logic [W-1:0] a_res,
    input logic [W-1:0] b_res
);

    logic idle_keep;
    assign idle_keep = en_ab && !en_ba_n && !sel_ab && !sel_ba && !a_ext && !b_ext;

    p_oe_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == en_ab) && (a_oe == !en_ba_n));

    p_isolation_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ab && en_ba_n) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    p_capture_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_ab) |=> (reg_ab == $past(a_res)));

    p_capture_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_ba) |=> (reg_ba == $past(b_res)));

    p_no_recapture_ab_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cap_ab) |=> $stable(reg_ab));

    p_no_recapture_ba_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cap_ba) |=> $stable(reg_ba));

    p_keeper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_keep && $past(idle_keep)) |-> ($stable(a_out) && $stable(b_out)));

endmodule

bind dual_bus_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_ab   (en_ab),
    .en_ba_n (en_ba_n),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .cap_ab  (cap_ab),
    .cap_ba  (cap_ba),
    .a_ext   (a_ext),
    .b_ext   (b_ext),
    .a_out   (a_out),
    .b_out   (b_out),
    .a_oe    (a_oe),
    .b_oe    (b_oe),
    .reg_ab  (reg_ab),
    .reg_ba  (reg_ba),
    .a_res   (a_res),
    .b_res   (b_res)
);

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic         cap_ab = 1'b0, cap_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_ext = 1'b0, b_ext = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [W-1:0] m_ab = '0, m_ba = '0, m_ha = '0, m_hb = '0;
    logic         m_pab = 1'b0, m_pba = 1'b0;

    always #4 clk = ~clk;

    dual_bus_xcvr #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic eab, input logic ebn, input logic sab, input logic sba,
                        input logic ae, input logic be, input logic [W-1:0] ai, input logic [W-1:0] bi,
                        input logic cab, input logic cba, input string tag);
        logic keep, aoe, boe;
        logic [W-1:0] ab, bb, ares, bres, ea, eb;
        @(negedge clk);
        en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
        a_ext = ae; b_ext = be; a_in = ai; b_in = bi; cap_ab = cab; cap_ba = cba;
        #1;
        aoe  = !ebn;
        boe  = eab;
        keep = eab && !ebn && !sab && !sba;
        ab = ae ? ai : ((aoe && sba) ? m_ba : m_ha);
        bb = be ? bi : ((boe && sab) ? m_ab : m_hb);
        if (keep) begin
            ares = ae ? ai : (be ? bi : m_ha);
            bres = be ? bi : (ae ? ai : m_hb);
            ea   = be ? bi : (ae ? ai : m_ha);
            eb   = ae ? ai : (be ? bi : m_hb);
        end else begin
            ares = (aoe && !sba) ? (ae ? ai : bb) : ab;
            bres = (boe && !sab) ? (be ? bi : ab) : bb;
            ea   = !aoe ? '0 : (sba ? m_ba : bb);
            eb   = !boe ? '0 : (sab ? m_ab : ab);
        end
        check(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, aoe});
        check(tag, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, boe});
        check(tag, "a_out", a_out, ea);
        check(tag, "b_out", b_out, eb);
        @(posedge clk);
        if (cab && !m_pab) m_ab = ares;
        if (cba && !m_pba) m_ba = bres;
        m_pab = cab; m_pba = cba;
        m_ha = ares; m_hb = bres;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: both stored paths read zero after reset
        step(1, 0, 1, 1, 0, 0, 8'hFF, 8'hEE, 0, 0, "R1");
        // R2: capture while isolated (R4), then read out stored on B
        step(0, 1, 0, 0, 1, 0, 8'h5A, 8'h00, 1, 0, "R2");
        step(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R2");
        // R3: capture B while only B drives
        step(1, 1, 0, 0, 0, 1, 8'h00, 8'hA5, 0, 1, "R3");
        step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, 0, 0, "R3");
        // R4: isolation
        step(0, 1, 1, 1, 1, 1, 8'h12, 8'h34, 0, 0, "R4");
        // R10: held strobes capture once
        step(1, 0, 1, 1, 1, 1, 8'h11, 8'h22, 1, 1, "R10");
        step(1, 0, 1, 1, 1, 1, 8'h33, 8'h44, 1, 1, "R10");
        step(1, 0, 1, 1, 0, 0, 8'h55, 8'h66, 1, 1, "R10");
        step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, 0, 0, "R10");
        // R5 / R6: live passes
        step(1, 1, 0, 0, 1, 0, 8'h42, 8'h00, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 8'h00, 8'h24, 0, 0, "R6");
        // R7: A driven live from B, store B into both registers
        step(0, 0, 0, 0, 0, 1, 8'h00, 8'hC3, 1, 1, "R7");
        step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, 0, 0, "R7");
        // R9: stored swap ignores outside drivers
        step(1, 0, 1, 1, 1, 1, 8'h77, 8'h88, 0, 0, "R9");
        // R8: keeper
        step(1, 0, 0, 0, 1, 0, 8'h3C, 8'h00, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 8'hFF, 8'hFF, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 1, 8'h00, 8'h99, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R8");

        // pseudo-random walk over all control combinations
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            if (lf[0] && !lf[1] && !lf[2] && !lf[3])         tag = "R8";
            else if (!lf[0] && lf[1])                        tag = "R4";
            else if (lf[4] || lf[5])                         tag = "R9";
            else                                             tag = lf[6] ? "R5" : "R6";
            step(lf[0], lf[1], lf[2], lf[3], lf[4], lf[5], lf[15:8], lf[23:16],
                 lf[24] & lf[25], lf[26] & lf[27], tag);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule